// File: doc/BRIEF.md
# Counter-Indexed Parallel Sequence Generator

This block plays back one fixed binary pattern of `SEQ_BITS` bits, delivering `WORD_BITS` bits on each enabled clock. The pattern is a constant parameter. It is cut into `M = ceil(SEQ_BITS/WORD_BITS)` words. Word i holds pattern bits i*WORD_BITS up to i*WORD_BITS+WORD_BITS-1, and bit j of word i is pattern bit i*WORD_BITS+j. If the pattern length is not a multiple of the word width, the bits of the last word that lie beyond the pattern are zero.

The state has two parts. An index register of `R = max(2, ceil(log2 M))` bits gives each word position its own state. A `WORD_BITS`-wide output register loads its next value from a function of the index bits alone. The index register is a maximal-length shift register when `M < 2^R`, and a plain up-counter when M fills the whole index space. Each position has a unique index value, so the output logic never looks at the output bits.

After the last word the index returns to its start value, so the pattern repeats every M enabled clocks. The index is brought out on a port for debug. A parameter can replace the output register with a direct combinational path from the mapping logic.

Top module: `seqgen_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `indexState` loads the start value and `outWord` clears to zero. The start value is `LFSR_SEED` (default 4'b0001) in shift-register mode and zero in counter mode.
- R2: Each rising edge with `enable` high and `rst` low loads `outWord` with the next word of the pattern. The first such edge after reset loads word 0, so word 0 appears one clock after `enable` is first seen high. Bit j of word i is pattern bit i*WORD_BITS+j.
- R3: After word M-1 has been loaded, `indexState` is back at its start value and the next enabled edge loads word 0 again, giving a period of M enabled clocks.
- R4: A rising edge with `enable` low leaves both `outWord` and `indexState` unchanged.
- R5: In shift-register mode (M < 2^R), `indexState` is never all zeros. Each step updates the bits as bit R-1 takes the XOR of the state bits selected by `LFSR_TAPS`, and bit k takes bit k+1 for k < R-1. With the defaults (R=4, taps 4'b0011) this gives new bit3 = bit0 xor bit1.
- R6: In counter mode (M = 2^R), `indexState` starts at zero and increases by one on each enabled edge, wrapping from M-1 to zero.
- R7: In the last word, the bits at positions at or beyond `SEQ_BITS` read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advance by one word when high |
| outWord | output | WORD_BITS | Current word of the pattern |
| indexState | output | R | Index register value, for debug |

## Verification
If the index register takes a wrong value, `outWord` shows a wrong word at the very next enabled edge. The index port shows the same error in the same cycle, so a wrong step, a missed reload or a zero-lock of the shift register appears at once. A reload at the wrong place in the period shows up at the wrap, where word 0 or the start index comes one step early or late. A wrong hold on a disabled cycle shifts every later word by one position.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;

  typedef struct packed {
    logic load;   // advance index, capture mapped word
    logic first;  // the word being captured is word 0
  } seqStrobe_t;

  function automatic int wordCount(int n, int p);
    return (n + p - 1) / p;
  endfunction

  function automatic int idxWidth(int n, int p);
    int r;
    r = $clog2(wordCount(n, p));
    if (r < 2) r = 2;
    return r;
  endfunction

  function automatic bit useLfsr(int n, int p);
    return wordCount(n, p) < (1 << idxWidth(n, p));
  endfunction

  function automatic logic [31:0] idxMask(int r);
    return (32'h1 << r) - 32'h1;
  endfunction

  // One step of the index generator, held in the low r bits.
  function automatic logic [31:0] stepIdx(logic [31:0] s, int r,
                                          logic [31:0] taps, bit lfsr);
    logic fb;
    if (lfsr) begin
      fb = ^(s & taps & idxMask(r));
      return ((s >> 1) | ({31'b0, fb} << (r - 1))) & idxMask(r);
    end
    return (s + 32'h1) & idxMask(r);
  endfunction

  // Index value that selects the final word of the period.
  function automatic logic [31:0] lastIdx(int m, int r, logic [31:0] taps,
                                          logic [31:0] seed, bit lfsr);
    logic [31:0] s;
    s = seed & idxMask(r);
    for (int i = 1; i < m; i++) s = stepIdx(s, r, taps, lfsr);
    return s;
  endfunction

endpackage

// File: rtl/seqgen_ctrl.sv
module seqgen_ctrl
  import seqgen_pkg::*;
#(
  parameter int          SEQ_BITS  = 40,
  parameter int          WORD_BITS = 4,
  parameter logic [31:0] LFSR_TAPS = 32'h3,
  parameter logic [31:0] LFSR_SEED = 32'h1
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       enable,
  output logic [idxWidth(SEQ_BITS, WORD_BITS)-1:0]   indexState,
  output seqStrobe_t                                 strobes
);

  localparam int            M        = wordCount(SEQ_BITS, WORD_BITS);
  localparam int            R        = idxWidth(SEQ_BITS, WORD_BITS);
  localparam bit            USE_LFSR = useLfsr(SEQ_BITS, WORD_BITS);
  localparam logic [R-1:0]  SEED     = USE_LFSR ? LFSR_SEED[R-1:0] : '0;
  localparam logic [R-1:0]  LAST     = R'(lastIdx(M, R, LFSR_TAPS, 32'(SEED), USE_LFSR));

  always_ff @(posedge clk) begin
    if (rst)
      indexState <= SEED;
    else if (enable)
      indexState <= (indexState == LAST) ? SEED
                  : R'(stepIdx(32'(indexState), R, LFSR_TAPS, USE_LFSR));
  end

  always_comb begin
    strobes.load  = enable;
    strobes.first = enable && (indexState == SEED);
  end

  // Independent step counter used only to watch the period.
  logic [R:0] stepsDone;
  always_ff @(posedge clk) begin
    if (rst)
      stepsDone <= '0;
    else if (enable)
      stepsDone <= (stepsDone == (R+1)'(M - 1)) ? '0 : stepsDone + 1'b1;
  end

  AST_PERIOD_SEED: assert property (@(posedge clk) disable iff (rst)
    (stepsDone == '0) |-> (indexState == SEED)) else $error("period seed"); // R3

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(indexState)) else $error("index hold"); // R4

  generate
    if (USE_LFSR) begin : g_lfsrChk
      AST_IDX_NONZERO: assert property (@(posedge clk) disable iff (rst)
        indexState != '0) else $error("index zero"); // R5
    end
  endgenerate

endmodule

// File: rtl/seqgen_dpath.sv
module seqgen_dpath
  import seqgen_pkg::*;
#(
  parameter int                    SEQ_BITS    = 40,
  parameter int                    WORD_BITS   = 4,
  parameter logic [SEQ_BITS-1:0]   SEQ_PATTERN = 40'hC3A596F01E,
  parameter logic [31:0]           LFSR_TAPS   = 32'h3,
  parameter logic [31:0]           LFSR_SEED   = 32'h1,
  parameter bit                    REG_OUT     = 1'b1
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic [idxWidth(SEQ_BITS, WORD_BITS)-1:0]   indexState,
  input  seqStrobe_t                                 strobes,
  output logic [WORD_BITS-1:0]                       outWord
);

  localparam int  M        = wordCount(SEQ_BITS, WORD_BITS);
  localparam int  R        = idxWidth(SEQ_BITS, WORD_BITS);
  localparam bit  USE_LFSR = useLfsr(SEQ_BITS, WORD_BITS);
  localparam logic [R-1:0] SEED = USE_LFSR ? LFSR_SEED[R-1:0] : '0;
  localparam logic [M*WORD_BITS-1:0] PADDED = (M*WORD_BITS)'(SEQ_PATTERN);
  localparam logic [WORD_BITS-1:0]   WORD0  = PADDED[WORD_BITS-1:0];

  // Walk the index sequence from the seed; the match selects the word.
  logic [WORD_BITS-1:0] mapped;
  logic [31:0]          walk;
  always_comb begin
    mapped = '0;
    walk   = 32'(SEED);
    for (int i = 0; i < M; i++) begin
      if (32'(indexState) == walk) mapped = PADDED[i*WORD_BITS +: WORD_BITS];
      walk = stepIdx(walk, R, LFSR_TAPS, USE_LFSR);
    end
  end

  generate
    if (REG_OUT) begin : g_regOut
      always_ff @(posedge clk) begin
        if (rst)               outWord <= '0;
        else if (strobes.load) outWord <= mapped;
      end

      AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !strobes.load |=> $stable(outWord)) else $error("out hold"); // R4

      AST_FIRST_WORD: assert property (@(posedge clk) disable iff (rst)
        strobes.first |=> (outWord == WORD0)) else $error("first word"); // R3
    end else begin : g_combOut
      assign outWord = mapped;
    end
  endgenerate

endmodule

// File: rtl/seqgen_top.sv
module seqgen_top
  import seqgen_pkg::*;
#(
  parameter int                    SEQ_BITS    = 40,
  parameter int                    WORD_BITS   = 4,
  parameter logic [SEQ_BITS-1:0]   SEQ_PATTERN = 40'hC3A596F01E,
  parameter logic [31:0]           LFSR_TAPS   = 32'h3,
  parameter logic [31:0]           LFSR_SEED   = 32'h1,
  parameter bit                    REG_OUT     = 1'b1
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       enable,
  output logic [WORD_BITS-1:0]                       outWord,
  output logic [idxWidth(SEQ_BITS, WORD_BITS)-1:0]   indexState
);

  seqStrobe_t strobes;

  seqgen_ctrl #(
    .SEQ_BITS (SEQ_BITS),
    .WORD_BITS(WORD_BITS),
    .LFSR_TAPS(LFSR_TAPS),
    .LFSR_SEED(LFSR_SEED)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .indexState(indexState),
    .strobes   (strobes)
  );

  seqgen_dpath #(
    .SEQ_BITS   (SEQ_BITS),
    .WORD_BITS  (WORD_BITS),
    .SEQ_PATTERN(SEQ_PATTERN),
    .LFSR_TAPS  (LFSR_TAPS),
    .LFSR_SEED  (LFSR_SEED),
    .REG_OUT    (REG_OUT)
  ) dpath_i (
    .clk       (clk),
    .rst       (rst),
    .indexState(indexState),
    .strobes   (strobes),
    .outWord   (outWord)
  );

endmodule

// File: tb/seqgen_top_tb_top.sv
module seqgen_top_tb_top;

  localparam logic [63:0] PAT_A = 64'h000000C3A596F01E;  // 40 bits, 10 words
  localparam logic [63:0] PAT_B = 64'h2D4BF00F1234ABCD;  // 62 bits, 16 words

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [3:0] outA, idxA, outB, idxB;

  always #4 clk = ~clk;  // 125 MHz

  seqgen_top dut_i (
    .clk(clk), .rst(rst), .enable(enable), .outWord(outA), .indexState(idxA)
  );

  seqgen_top #(
    .SEQ_BITS(62), .WORD_BITS(4), .SEQ_PATTERN(62'(PAT_B))
  ) dutCnt_i (
    .clk(clk), .rst(rst), .enable(enable), .outWord(outB), .indexState(idxB)
  );

  typedef struct {
    logic [3:0] wA, iA, wB, iB;
    string      tag;
  } expItem_t;

  expItem_t q[$];
  int checks = 0;
  int fails  = 0;
  int stepA  = 0;
  int stepB  = 0;
  logic [3:0] expWA = 4'h0, expIA = 4'h1, expWB = 4'h0, expIB = 4'h0;

  function automatic logic [3:0] wordOf(logic [63:0] pat, int k);
    return pat[k*4 +: 4];
  endfunction

  function automatic logic [3:0] lfsrAt(int k);
    logic [3:0] s = 4'b0001;
    for (int i = 0; i < k; i++) s = {s[0] ^ s[1], s[3:1]};
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Driver: sets enable and pushes the expected state after the next edge.
  task automatic drive(input logic en, input int cycles);
    expItem_t it;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      enable = en;
      if (en) begin
        expWA = wordOf(PAT_A, stepA);
        stepA = (stepA + 1) % 10;
        expIA = lfsrAt(stepA);
        expWB = wordOf(PAT_B, stepB);
        stepB = (stepB + 1) % 16;
        expIB = 4'(stepB);
      end
      it.wA = expWA; it.iA = expIA; it.wB = expWB; it.iB = expIB;
      it.tag = en ? "R2" : "R4";
      q.push_back(it);
    end
  endtask

  // Monitor: compares after every edge that has a pending expectation.
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        check(outA == it.wA, it.tag, "lfsr-mode word", 32'(outA), 32'(it.wA));
        check(outB == it.wB, it.tag, "counter-mode word", 32'(outB), 32'(it.wB));
        check(idxA == it.iA, (it.tag == "R4") ? "R4" : "R5", "lfsr index", 32'(idxA), 32'(it.iA));
        check(idxB == it.iB, (it.tag == "R4") ? "R4" : "R6", "counter index", 32'(idxB), 32'(it.iB));
        check(idxA != 4'h0, "R5", "lfsr index nonzero", 32'(idxA), 32'h1);
      end
    end
  end

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(outA == 4'h0, "R1", "lfsr-mode word after reset", 32'(outA), 32'h0);
    check(idxA == 4'h1, "R1", "lfsr index after reset", 32'(idxA), 32'h1);
    check(outB == 4'h0, "R1", "counter-mode word after reset", 32'(outB), 32'h0);
    check(idxB == 4'h0, "R1", "counter index after reset", 32'(idxB), 32'h0);
    rst = 1'b0;

    drive(1'b1, 10);
    drive(1'b0, 1);
    // R3: one full period of the 10-word pattern
    check(idxA == 4'h1, "R3", "lfsr index back at seed", 32'(idxA), 32'h1);
    check(outA == wordOf(PAT_A, 9), "R3", "last word of period", 32'(outA), 32'(wordOf(PAT_A, 9)));

    drive(1'b1, 6);
    drive(1'b0, 1);
    // R7: padded last word of the 62-bit pattern; R3 for the counter wrap
    check(outB == 4'h2, "R7", "padded last word", 32'(outB), 32'h2);
    check(idxB == 4'h0, "R3", "counter index wrapped", 32'(idxB), 32'h0);

    for (int i = 0; i < 12; i++) drive(1'(i % 2), 1);
    drive(1'b0, 5);
    drive(1'b1, 40);
    drive(1'b0, 2);
    @(negedge clk);
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule